// File: doc/BRIEF.md
# Timestamping Multi-Link Pixel Merger

The block gathers 48-bit pixel words arriving from several independent serial-link receivers and funnels them into one stream. As each word is accepted it is extended with a 20-bit coarse timestamp. The timestamp comes from a free-running counter that advances on a slow tick strobe and can be cleared synchronously. Each link owns a small queue of timestamped 68-bit words. A fair round-robin arbiter moves at most one word per cycle from those queues into a shared output queue. A downstream consumer reads that queue through a show-ahead interface.

The output queue raises an almost-full flag for throttle logic. When a link's own queue is full, a new word on that link is dropped and a sticky overflow bit is raised for that link. A full output queue stalls the merge, and nothing is lost in that case.

Top module: `pixel_merger`

## Requirements
- R1: Each output word is 68 bits. Bits [67:20] hold the 48-bit pixel word unchanged, and bits [19:0] hold the coarse timestamp. The pixel word itself is laid out as a 4-bit header in [47:44], a 16-bit address in [43:28], an 18-bit arrival time in [27:10] and a 10-bit duration in [9:0].
- R2: The coarse counter rises by one on each clock edge where `ts_tick_i` is high and `ts_clr_i` is low. It holds its value when neither input is high, and it wraps modulo 2^20. A word takes the value the counter holds at the edge where that word is sampled.
- R3: `ts_clr_i` high at an edge makes the counter zero after that edge, even if `ts_tick_i` is also high at that edge.
- R4: A word sampled at edge E on an otherwise empty path is still not visible after edge E. It is visible at `rd_data_o` after edge E+1, with `rd_empty_o` low.
- R5: Link queues that hold words are served one word per cycle. The search runs in cyclic link order, starting from the link after the last one served and skipping empty queues. After reset the search starts at link 0.
- R6: Words from a single link leave in the order they arrived.
- R7: A valid word on a link whose queue already holds LINK_DEPTH words is dropped. This sets that link's bit in `link_ovf_o`, and the bit stays set until reset.
- R8: The output queue holds up to OUT_DEPTH words. While it is full, merging pauses and the link queues keep their words.
- R9: `almost_full_o` is high exactly when the output queue holds at least OUT_AF_LEVEL words.
- R10: After reset the output queue is empty, `almost_full_o` is low, all overflow bits are clear, and the counter is zero.
- R11: `rd_en_i` while `rd_empty_o` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ts_tick_i | input | 1 | Advance strobe for the coarse counter |
| ts_clr_i | input | 1 | Synchronous clear of the coarse counter |
| link_valid_i | input | NUM_LINKS | Per-link word valid |
| link_data_i | input | NUM_LINKS*48 | Per-link pixel words, link i in bits [48*i+47:48*i] |
| rd_en_i | input | 1 | Pop the head of the output queue |
| rd_data_o | output | 68 | Head of the output queue (show-ahead) |
| rd_empty_o | output | 1 | Output queue empty |
| almost_full_o | output | 1 | Output queue at or above OUT_AF_LEVEL |
| link_ovf_o | output | NUM_LINKS | Sticky per-link drop flags |

## Verification
The bench builds the block with four links, link queues of depth 4, an output queue of depth 8 and an almost-full level of 6. With these small sizes, a burst of fourteen words on one link fills the output queue, then fills that link's queue, and then forces drops within a few dozen cycles. This exercises the stall, overflow and in-order drain paths together. Four links are enough to show the search skipping an empty link, wrapping past the last link, and resuming after the link served last. Counter wrap-around is covered by the increment property, since a full 2^20 tick sweep is out of reach for a directed run.

// File: rtl/pixmrg_pkg.sv
package pixmrg_pkg;
  localparam int PIX_W  = 48;
  localparam int TS_W   = 20;
  localparam int WORD_W = PIX_W + TS_W;

  typedef struct packed {
    logic [3:0]  hdr;
    logic [15:0] addr;
    logic [17:0] toa;
    logic [9:0]  tot;
  } pix_t;

  typedef struct packed {
    pix_t            pix;
    logic [TS_W-1:0] ts;
  } tword_t;
endpackage

// File: rtl/pixmrg_ts_ctr.sv
module pixmrg_ts_ctr #(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  output logic [W-1:0] ts_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;  // clear beats tick
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign ts_o = cnt_q;
endmodule

// File: rtl/pixmrg_fifo.sv
module pixmrg_fifo #(
  parameter int W     = 68,
  parameter int DEPTH = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [W-1:0]                 wr_data_i,
  input  logic                         rd_en_i,
  output logic [W-1:0]                 rd_data_o,
  output logic [$clog2(DEPTH+1)-1:0]   level_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign do_wr = wr_en_i && (cnt_q != CW'(DEPTH));
  assign do_rd = rd_en_i && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_wr) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (do_rd) rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rd_data_o = mem_q[rd_ptr_q];
  assign level_o   = cnt_q;
endmodule

// File: rtl/pixmrg_rr_arb.sv
module pixmrg_rr_arb #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         en_i,
  output logic [N-1:0] gnt_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q, sel;
  logic [N-1:0]  gnt;
  logic          found;

  always_comb begin
    gnt   = '0;
    sel   = last_q;
    found = 1'b0;
    for (int off = 1; off <= N; off++) begin
      int idx;
      idx = int'(last_q) + off;
      if (idx >= N) idx = idx - N;
      if (!found && req_i[idx]) begin
        gnt[idx] = 1'b1;
        sel      = IW'(idx);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             last_q <= IW'(N-1);  // first search starts at link 0
    else if (en_i && found)  last_q <= sel;
  end

  assign gnt_o = en_i ? gnt : '0;
endmodule

// File: rtl/pixel_merger.sv
module pixel_merger
  import pixmrg_pkg::*;
#(
  parameter int NUM_LINKS    = 8,
  parameter int LINK_DEPTH   = 16,
  parameter int OUT_DEPTH    = 64,
  parameter int OUT_AF_LEVEL = 48
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ts_tick_i,
  input  logic                       ts_clr_i,
  input  logic [NUM_LINKS-1:0]       link_valid_i,
  input  logic [NUM_LINKS*PIX_W-1:0] link_data_i,
  input  logic                       rd_en_i,
  output logic [WORD_W-1:0]          rd_data_o,
  output logic                       rd_empty_o,
  output logic                       almost_full_o,
  output logic [NUM_LINKS-1:0]       link_ovf_o
);
  localparam int LCW = $clog2(LINK_DEPTH+1);
  localparam int OCW = $clog2(OUT_DEPTH+1);

  logic [TS_W-1:0]      ts_val;
  logic [NUM_LINKS-1:0] link_empty, link_full, link_pop;
  logic [WORD_W-1:0]    link_head [NUM_LINKS];
  logic [WORD_W-1:0]    merged;
  logic [OCW-1:0]       out_cnt;
  logic                 out_full;
  logic [NUM_LINKS-1:0] ovf_q;

  pixmrg_ts_ctr #(.W(TS_W)) u_ts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (ts_tick_i),
    .clr_i  (ts_clr_i),
    .ts_o   (ts_val)
  );

  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
    tword_t         wr_word;
    logic [LCW-1:0] lvl;

    assign wr_word.pix = pix_t'(link_data_i[g*PIX_W +: PIX_W]);
    assign wr_word.ts  = ts_val;

    pixmrg_fifo #(.W(WORD_W), .DEPTH(LINK_DEPTH)) u_fifo (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (link_valid_i[g]),
      .wr_data_i (wr_word),
      .rd_en_i   (link_pop[g]),
      .rd_data_o (link_head[g]),
      .level_o   (lvl)
    );

    assign link_empty[g] = (lvl == '0);
    assign link_full[g]  = (lvl == LCW'(LINK_DEPTH));
  end

  pixmrg_rr_arb #(.N(NUM_LINKS)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (~link_empty),
    .en_i   (~out_full),
    .gnt_o  (link_pop)
  );

  // one-hot grant, AND-OR select
  always_comb begin
    merged = '0;
    for (int i = 0; i < NUM_LINKS; i++) begin
      if (link_pop[i]) merged = merged | link_head[i];
    end
  end

  pixmrg_fifo #(.W(WORD_W), .DEPTH(OUT_DEPTH)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (|link_pop),
    .wr_data_i (merged),
    .rd_en_i   (rd_en_i),
    .rd_data_o (rd_data_o),
    .level_o   (out_cnt)
  );

  assign out_full      = (out_cnt == OCW'(OUT_DEPTH));
  assign rd_empty_o    = (out_cnt == '0);
  assign almost_full_o = (out_cnt >= OCW'(OUT_AF_LEVEL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= '0;
    else         ovf_q <= ovf_q | (link_valid_i & link_full);
  end

  assign link_ovf_o = ovf_q;
endmodule

// File: rtl/pixel_merger_chk.sv
module pixel_merger_chk #(
  parameter int N         = 8,
  parameter int OUT_DEPTH = 64,
  parameter int TS_W      = 20
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           ts_tick_i,
  input logic                           ts_clr_i,
  input logic [TS_W-1:0]                ts_val,
  input logic [$clog2(OUT_DEPTH+1)-1:0] out_cnt,
  input logic [N-1:0]                   pop_vec,
  input logic                           rd_empty_o,
  input logic [N-1:0]                   link_ovf_o
);
  // R3
  ts_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_clr_i |=> ts_val == '0);

  // R2
  ts_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_tick_i && !ts_clr_i) |=> ts_val == TS_W'($past(ts_val) + 1'b1));

  // R2
  ts_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ts_tick_i && !ts_clr_i) |=> $stable(ts_val));

  // R5
  single_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pop_vec));

  // R8
  out_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_cnt <= OUT_DEPTH);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((link_ovf_o & $past(link_ovf_o)) == $past(link_ovf_o)));

  // R11
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_empty_o |=> out_cnt <= 1);
endmodule

bind pixel_merger pixel_merger_chk #(
  .N(NUM_LINKS), .OUT_DEPTH(OUT_DEPTH), .TS_W(pixmrg_pkg::TS_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ts_tick_i  (ts_tick_i),
  .ts_clr_i   (ts_clr_i),
  .ts_val     (ts_val),
  .out_cnt    (out_cnt),
  .pop_vec    (link_pop),
  .rd_empty_o (rd_empty_o),
  .link_ovf_o (link_ovf_o)
);

// File: tb/pixel_merger_bench.sv
module pixel_merger_bench;
  localparam int NL = 4;
  localparam int LD = 4;
  localparam int OD = 8;
  localparam int AF = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ts_tick_i = 1'b0;
  logic          ts_clr_i = 1'b0;
  logic [NL-1:0] link_valid_i = '0;
  logic [NL*48-1:0] link_data_i = '0;
  logic          rd_en_i = 1'b0;
  logic [67:0]   rd_data_o;
  logic          rd_empty_o;
  logic          almost_full_o;
  logic [NL-1:0] link_ovf_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pixel_merger #(.NUM_LINKS(NL), .LINK_DEPTH(LD), .OUT_DEPTH(OD), .OUT_AF_LEVEL(AF)) u_pixel_merger (
    .clk_i(clk_i), .rst_ni(rst_ni), .ts_tick_i(ts_tick_i), .ts_clr_i(ts_clr_i),
    .link_valid_i(link_valid_i), .link_data_i(link_data_i), .rd_en_i(rd_en_i),
    .rd_data_o(rd_data_o), .rd_empty_o(rd_empty_o), .almost_full_o(almost_full_o),
    .link_ovf_o(link_ovf_o)
  );

  function automatic logic [47:0] mk(int l, int k);
    return {8'(l), 8'(k), 32'h5A5A_0000 + 32'(k)};
  endfunction

  task automatic check(bit ok, string req, logic [67:0] act, logic [67:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; ts_tick_i = 0; ts_clr_i = 0; link_valid_i = '0; rd_en_i = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic send(logic [NL-1:0] mask, int k);
    link_valid_i = mask;
    for (int l = 0; l < NL; l++) link_data_i[l*48 +: 48] = mk(l, k);
    @(negedge clk_i);
    link_valid_i = '0;
  endtask

  task automatic pop_check(logic [67:0] exp, string req);
    check(!rd_empty_o, req, {67'd0, rd_empty_o}, 68'd0);
    check(rd_data_o == exp, req, rd_data_o, exp);
    rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  // R10 R2
  task automatic t_reset_state();
    do_reset();
    check(rd_empty_o == 1'b1, "R10", {67'd0, rd_empty_o}, 68'd1);
    check(almost_full_o == 1'b0, "R10", {67'd0, almost_full_o}, 68'd0);
    check(link_ovf_o == '0, "R10", 68'(link_ovf_o), 68'd0);
    send(4'b0001, 0);
    @(negedge clk_i);
    pop_check({mk(0, 0), 20'd0}, "R10");
  endtask

  // R4 R1
  task automatic t_latency_format();
    do_reset();
    send(4'b0100, 7);
    check(rd_empty_o == 1'b1, "R4", {67'd0, rd_empty_o}, 68'd1);
    @(negedge clk_i);
    check(rd_empty_o == 1'b0, "R4", {67'd0, rd_empty_o}, 68'd0);
    check(rd_data_o[67:20] == mk(2, 7), "R1", 68'(rd_data_o[67:20]), 68'(mk(2, 7)));
    check(rd_data_o[19:0] == 20'd0, "R1", 68'(rd_data_o[19:0]), 68'd0);
    pop_check({mk(2, 7), 20'd0}, "R1");
  endtask

  // R2
  task automatic t_timestamp_count();
    do_reset();
    ts_tick_i = 1'b1;
    repeat (5) @(negedge clk_i);
    ts_tick_i = 1'b0;
    send(4'b0001, 1);
    repeat (3) @(negedge clk_i);
    send(4'b0001, 2);
    ts_tick_i = 1'b1;
    repeat (2) @(negedge clk_i);
    ts_tick_i = 1'b0;
    send(4'b0001, 3);
    @(negedge clk_i);
    pop_check({mk(0, 1), 20'd5}, "R2");
    pop_check({mk(0, 2), 20'd5}, "R2");
    pop_check({mk(0, 3), 20'd7}, "R2");
  endtask

  // R3
  task automatic t_timestamp_clear();
    do_reset();
    ts_tick_i = 1'b1;
    repeat (10) @(negedge clk_i);
    ts_clr_i = 1'b1;
    @(negedge clk_i);
    ts_clr_i = 1'b0;
    send(4'b0010, 1);
    send(4'b0010, 2);
    ts_tick_i = 1'b0;
    @(negedge clk_i);
    pop_check({mk(1, 1), 20'd0}, "R3");
    pop_check({mk(1, 2), 20'd1}, "R3");
  endtask

  // R5
  task automatic t_round_robin();
    do_reset();
    send(4'b1011, 0);
    send(4'b1011, 1);
    repeat (6) @(negedge clk_i);
    pop_check({mk(0, 0), 20'd0}, "R5");
    pop_check({mk(1, 0), 20'd0}, "R5");
    pop_check({mk(3, 0), 20'd0}, "R5");
    pop_check({mk(0, 1), 20'd0}, "R5");
    pop_check({mk(1, 1), 20'd0}, "R5");
    pop_check({mk(3, 1), 20'd0}, "R5");
    send(4'b0100, 2);
    @(negedge clk_i);
    pop_check({mk(2, 2), 20'd0}, "R5");
    send(4'b1011, 3);
    repeat (4) @(negedge clk_i);
    pop_check({mk(3, 3), 20'd0}, "R5");
    pop_check({mk(0, 3), 20'd0}, "R5");
    pop_check({mk(1, 3), 20'd0}, "R5");
  endtask

  // R7 R8 R6
  task automatic t_overflow();
    do_reset();
    for (int k = 0; k < 14; k++) send(4'b0001, k);
    repeat (2) @(negedge clk_i);
    check(link_ovf_o == 4'b0001, "R7", 68'(link_ovf_o), 68'd1);
    check(almost_full_o == 1'b1, "R8", {67'd0, almost_full_o}, 68'd1);
    for (int k = 0; k < 12; k++) pop_check({mk(0, k), 20'd0}, "R6");
    @(negedge clk_i);
    check(rd_empty_o == 1'b1, "R8", {67'd0, rd_empty_o}, 68'd1);
    check(link_ovf_o == 4'b0001, "R7", 68'(link_ovf_o), 68'd1);
  endtask

  // R9
  task automatic t_almost_full();
    do_reset();
    for (int k = 0; k < 5; k++) send(4'b0010, k);
    repeat (2) @(negedge clk_i);
    check(almost_full_o == 1'b0, "R9", {67'd0, almost_full_o}, 68'd0);
    send(4'b0010, 5);
    @(negedge clk_i);
    check(almost_full_o == 1'b1, "R9", {67'd0, almost_full_o}, 68'd1);
    pop_check({mk(1, 0), 20'd0}, "R9");
    check(almost_full_o == 1'b0, "R9", {67'd0, almost_full_o}, 68'd0);
    for (int k = 1; k < 6; k++) pop_check({mk(1, k), 20'd0}, "R9");
  endtask

  // R11
  task automatic t_empty_read();
    do_reset();
    rd_en_i = 1'b1;
    repeat (3) @(negedge clk_i);
    rd_en_i = 1'b0;
    check(rd_empty_o == 1'b1, "R11", {67'd0, rd_empty_o}, 68'd1);
    send(4'b1000, 9);
    @(negedge clk_i);
    pop_check({mk(3, 9), 20'd0}, "R11");
    check(rd_empty_o == 1'b1, "R11", {67'd0, rd_empty_o}, 68'd1);
  endtask

  initial begin
    t_reset_state();
    t_latency_format();
    t_timestamp_count();
    t_timestamp_clear();
    t_round_robin();
    t_overflow();
    t_almost_full();
    t_empty_read();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule